// File: doc/BRIEF.md
# Platform-Level Interrupt Controller

This block gathers interrupt requests from a set of sources and routes them to a small number of targets (contexts), each of which owns one interrupt output. Every source passes through its own gateway, built at elaboration time as either level-sensitive or edge-sensitive. A gateway forwards one request into a central pending bit and then holds off further requests from that source until software signals completion. A level gateway remembers a request that arrives while it is busy. An edge gateway drops such a request.

Software programs a priority per source and, for each context, an enable bit per source and a priority threshold. All of this goes through a 32-bit word-addressed register port. Reading a context's claim register returns the best eligible source, which is highest priority first and lowest ID on a tie, and clears that source's pending bit. Writing a source ID to the same register completes the interrupt and re-arms the gateway. Each context's output is computed every cycle from the current state and then registered.

Top module: `plic_top`

## Requirements
- R1: After reset every priority, pending bit, enable bit and threshold reads 0, and every `irq_o` bit is 0.
- R2: The priority of source s is at byte offset 4*s and keeps its low PRIO_W bits. Source 0 is reserved: its priority and enable bits always read 0, it never becomes pending and it never interrupts.
- R3: Enable bits for context c sit at 0x2000 + 0x80*c + 4*w, with source s in word s/32 at bit s%32. The threshold of context c is at 0x200000 + 0x1000*c. A source qualifies for a context only when it is pending, it is enabled for that context, and its priority is strictly greater than that context's threshold.
- R4: `irq_o[c]` is a register that goes high on the clock edge after some source qualifies for context c and low on the edge after none does. When nothing is pending, every output is 0 one cycle later.
- R5: A read of the claim register at threshold address + 4 returns the qualifying source with the highest priority, taking the lowest ID on a tie, or 0 if none qualifies. It clears that source's pending bit.
- R6: A ready gateway forwards a request to the pending bit and becomes busy. A busy gateway forwards nothing until that source's ID is written to a claim register.
- R7: Sources whose bit is set in LEVEL_MASK are level-sensitive: a high request seen while busy is latched and forwarded as soon as completion re-arms the gateway. The other sources react to rising edges only, and an edge seen while busy is lost.
- R8: A completion write has no effect unless the written ID is enabled for the context whose register is written.
- R9: The pending words at 0x1000 + 4*w are read-only. Any read of an offset that is unmapped or not word-aligned returns 0.
- R10: A claim read and a new request from another source in the same cycle both take effect.
- R11: `reg_rdata` carries the result of a read on the cycle after `reg_rd` and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | NUM_SRC | Interrupt request per source |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe (a claim read has side effects) |
| reg_rdata | output | 32 | Registered read data |
| irq_o | output | NUM_CTX | Interrupt output per context |

## Verification
The hardest states to reach are those where a gateway is busy and a second request arrives. In that state a level source must latch the request and an edge source must drop it, and the outcome can only be seen after a completion write that may itself be ignored. The bench drives each source through claim, a repeated request, a completion write to a context that does not enable it, and then a valid completion. It reads the pending word after every step. It also pends every source at once and drains them by repeated claims, and compares each claim result against an arithmetic model of priority and tie order.

// File: rtl/plic_pkg.sv
package plic_pkg;

    localparam int unsigned PEND_BASE  = 32'h0000_1000;
    localparam int unsigned EN_BASE    = 32'h0000_2000;
    localparam int unsigned EN_STRIDE  = 32'h0000_0080;
    localparam int unsigned CTX_BASE   = 32'h0020_0000;
    localparam int unsigned CTX_STRIDE = 32'h0000_1000;
    localparam int unsigned CLAIM_OFS  = 32'h0000_0004;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_PRIO,
        REG_PEND,
        REG_EN,
        REG_THR,
        REG_CLAIM
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e   kind;
        logic [15:0] index;   // source number or word number
        logic [7:0]  ctx;     // context number
    } reg_sel_t;

    function automatic reg_sel_t decode_addr(input logic [31:0] a,
                                             input int unsigned nsrc,
                                             input int unsigned nctx,
                                             input int unsigned nwords);
        reg_sel_t    r;
        int unsigned off;
        r.kind  = REG_NONE;
        r.index = '0;
        r.ctx   = '0;
        off     = 0;
        if (a[1:0] == 2'b00) begin
            if (a < PEND_BASE) begin
                if ((a >> 2) < nsrc) begin
                    r.kind  = REG_PRIO;
                    r.index = 16'(a >> 2);
                end
            end else if (a < PEND_BASE + 4 * nwords) begin
                r.kind  = REG_PEND;
                r.index = 16'((a - PEND_BASE) >> 2);
            end else if (a >= EN_BASE && a < EN_BASE + EN_STRIDE * nctx) begin
                off = a - EN_BASE;
                if (((off % EN_STRIDE) >> 2) < nwords) begin
                    r.kind  = REG_EN;
                    r.index = 16'((off % EN_STRIDE) >> 2);
                    r.ctx   = 8'(off / EN_STRIDE);
                end
            end else if (a >= CTX_BASE && a < CTX_BASE + CTX_STRIDE * nctx) begin
                off   = a - CTX_BASE;
                r.ctx = 8'(off / CTX_STRIDE);
                if ((off % CTX_STRIDE) == 0)
                    r.kind = REG_THR;
                else if ((off % CTX_STRIDE) == CLAIM_OFS)
                    r.kind = REG_CLAIM;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/plic_gateway.sv
module plic_gateway #(
    parameter bit LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    input  logic done_i,
    output logic fire_o
);
    logic ready_q;
    logic held_q;
    logic req_q;
    logic arrive;

    generate
        if (LEVEL) begin : g_level
            assign arrive = req_i;
        end else begin : g_edge
            assign arrive = req_i & ~req_q;
        end
    endgenerate

    assign fire_o = ready_q & (arrive | held_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ready_q <= 1'b1;
            held_q  <= 1'b0;
            req_q   <= 1'b0;
        end else begin
            req_q <= req_i;
            if (fire_o)
                ready_q <= 1'b0;
            else if (done_i)
                ready_q <= 1'b1;
            if (fire_o)
                held_q <= 1'b0;
            else if (LEVEL && !ready_q && arrive)
                held_q <= 1'b1;
        end
    end

    // R6: a busy gateway with no completion stays silent next cycle
    p_busy_blocks_r6: assert property (@(posedge clk) disable iff (rst)
        (!ready_q && !done_i) |=> !fire_o);

    generate
        if (LEVEL) begin : g_lvl_chk
            // R7: level request while busy is remembered
            p_level_latch_r7: assert property (@(posedge clk) disable iff (rst)
                (!ready_q && req_i) |=> held_q);
        end else begin : g_edge_chk
            // R7: edge gateway never holds a request
            p_edge_no_hold_r7: assert property (@(posedge clk) disable iff (rst)
                !held_q);
        end
    endgenerate

endmodule

// File: rtl/plic_arbiter.sv
module plic_arbiter #(
    parameter int NUM_SRC = 32,
    parameter int PRIO_W  = 3,
    localparam int ID_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]        cand_i,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]         thr_i,
    output logic                      valid_o,
    output logic [ID_W-1:0]           id_o
);
    logic [PRIO_W-1:0] best;
    logic [PRIO_W-1:0] p;

    always_comb begin
        valid_o = 1'b0;
        id_o    = '0;
        best    = '0;
        p       = '0;
        for (int s = 1; s < NUM_SRC; s++) begin
            p = prio_i[s*PRIO_W +: PRIO_W];
            if (cand_i[s] && (p > thr_i) && (!valid_o || p > best)) begin
                valid_o = 1'b1;
                best    = p;
                id_o    = ID_W'(s);
            end
        end
    end

endmodule

// File: rtl/plic_top.sv
module plic_top #(
    parameter int                 NUM_SRC    = 32,
    parameter int                 NUM_CTX    = 2,
    parameter int                 PRIO_W     = 3,
    parameter int                 ADDR_W     = 24,
    parameter logic [NUM_SRC-1:0] LEVEL_MASK = 32'hFFFF_0000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic [31:0]        reg_wdata,
    input  logic               reg_rd,
    output logic [31:0]        reg_rdata,
    output logic [NUM_CTX-1:0] irq_o
);
    import plic_pkg::*;

    localparam int ID_W   = $clog2(NUM_SRC);
    localparam int NWORDS = (NUM_SRC + 31) / 32;

    logic [PRIO_W-1:0]        prio_q [NUM_SRC];
    logic [NUM_SRC-1:0]       pend_q;
    logic [NUM_SRC-1:0]       en_q   [NUM_CTX];
    logic [PRIO_W-1:0]        thr_q  [NUM_CTX];
    logic [NUM_CTX-1:0]       irq_q;

    logic [NUM_SRC*PRIO_W-1:0] prio_flat;
    logic [NUM_SRC-1:0]        fire_vec;
    logic [NUM_SRC-1:0]        done_vec;
    logic [NUM_SRC-1:0]        clr_vec;
    logic [NUM_SRC-1:0]        pend_d;
    logic                      win_v  [NUM_CTX];
    logic [ID_W-1:0]           win_id [NUM_CTX];

    reg_sel_t                  sel;
    logic                      claim_hit;
    logic                      claim_v;
    logic [ID_W-1:0]           claim_id;
    logic [31:0]               rd_d;

    assign sel = decode_addr(32'(reg_addr), NUM_SRC, NUM_CTX, NWORDS);

    // ---------------- gateways ----------------
    generate
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_gw
            plic_gateway #(.LEVEL(LEVEL_MASK[s])) gw_i (
                .clk   (clk),
                .rst   (rst),
                .req_i (src_req[s]),
                .done_i(done_vec[s]),
                .fire_o(fire_vec[s])
            );
        end
    endgenerate

    // ---------------- arbitration per context ----------------
    always_comb begin
        for (int s = 0; s < NUM_SRC; s++)
            prio_flat[s*PRIO_W +: PRIO_W] = prio_q[s];
    end

    generate
        for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
            plic_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) arb_i (
                .cand_i (pend_q & en_q[c]),
                .prio_i (prio_flat),
                .thr_i  (thr_q[c]),
                .valid_o(win_v[c]),
                .id_o   (win_id[c])
            );

            // R5: the winner is pending, enabled and never source 0
            p_winner_ok_r5: assert property (@(posedge clk) disable iff (rst)
                win_v[c] |-> (pend_q[win_id[c]] && en_q[c][win_id[c]] && win_id[c] != '0));
            // R3: the winner beats the context threshold
            p_above_thr_r3: assert property (@(posedge clk) disable iff (rst)
                win_v[c] |-> (prio_q[win_id[c]] > thr_q[c]));
        end
    endgenerate

    // ---------------- claim / complete ----------------
    always_comb begin
        claim_v  = 1'b0;
        claim_id = '0;
        for (int c = 0; c < NUM_CTX; c++) begin
            if (int'(sel.ctx) == c) begin
                claim_v  = win_v[c];
                claim_id = win_id[c];
            end
        end
    end

    assign claim_hit = reg_rd && (sel.kind == REG_CLAIM);

    always_comb begin
        clr_vec  = '0;
        done_vec = '0;
        for (int s = 1; s < NUM_SRC; s++) begin
            if (claim_hit && claim_v && int'(claim_id) == s)
                clr_vec[s] = 1'b1;
            for (int c = 0; c < NUM_CTX; c++) begin
                if (reg_wr && sel.kind == REG_CLAIM && int'(sel.ctx) == c &&
                    reg_wdata == 32'(s) && en_q[c][s])
                    done_vec[s] = 1'b1;
            end
        end
    end

    always_comb begin
        pend_d    = (pend_q & ~clr_vec) | fire_vec;
        pend_d[0] = 1'b0;
    end

    // ---------------- read mux ----------------
    always_comb begin
        rd_d = '0;
        case (sel.kind)
            REG_PRIO: begin
                for (int s = 1; s < NUM_SRC; s++)
                    if (int'(sel.index) == s) rd_d[PRIO_W-1:0] = prio_q[s];
            end
            REG_PEND: begin
                for (int s = 0; s < NUM_SRC; s++)
                    if (int'(sel.index) == s / 32) rd_d[s % 32] = pend_q[s];
            end
            REG_EN: begin
                for (int c = 0; c < NUM_CTX; c++)
                    for (int s = 0; s < NUM_SRC; s++)
                        if (int'(sel.ctx) == c && int'(sel.index) == s / 32)
                            rd_d[s % 32] = en_q[c][s];
            end
            REG_THR: begin
                for (int c = 0; c < NUM_CTX; c++)
                    if (int'(sel.ctx) == c) rd_d[PRIO_W-1:0] = thr_q[c];
            end
            REG_CLAIM: rd_d = claim_v ? 32'(claim_id) : 32'd0;
            default:   rd_d = '0;
        endcase
    end

    // ---------------- state ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SRC; s++) prio_q[s] <= '0;
            for (int c = 0; c < NUM_CTX; c++) begin
                en_q[c]  <= '0;
                thr_q[c] <= '0;
            end
            pend_q    <= '0;
            irq_q     <= '0;
            reg_rdata <= '0;
        end else begin
            pend_q <= pend_d;
            for (int c = 0; c < NUM_CTX; c++) irq_q[c] <= win_v[c];
            if (reg_rd) reg_rdata <= rd_d;
            if (reg_wr) begin
                for (int s = 1; s < NUM_SRC; s++)
                    if (sel.kind == REG_PRIO && int'(sel.index) == s)
                        prio_q[s] <= reg_wdata[PRIO_W-1:0];
                for (int c = 0; c < NUM_CTX; c++) begin
                    if (sel.kind == REG_THR && int'(sel.ctx) == c)
                        thr_q[c] <= reg_wdata[PRIO_W-1:0];
                    for (int s = 1; s < NUM_SRC; s++)
                        if (sel.kind == REG_EN && int'(sel.ctx) == c &&
                            int'(sel.index) == s / 32)
                            en_q[c][s] <= reg_wdata[s % 32];
                end
            end
        end
    end

    assign irq_o = irq_q;

    // R5: a claimed source is cleared unless it re-fires in the same cycle
    p_claim_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (claim_hit && claim_v && !fire_vec[claim_id]) |=> !pend_q[$past(claim_id)]);
    // R4: with nothing pending every output drops one cycle later
    p_irq_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (pend_q == '0) |=> (irq_o == '0));
    // R9: unmapped reads return zero
    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && sel.kind == REG_NONE) |=> (reg_rdata == 32'd0));
    // R2: source 0 never pending
    p_src0_idle_r2: assert property (@(posedge clk) disable iff (rst)
        $past(src_req[0]) |-> !pend_q[0]);

endmodule

// File: tb/plic_top_tb_top.sv
`timescale 1ns/1ps
module plic_top_tb_top;
    localparam int NSRC = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src_req = '0;
    logic [23:0] reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_rdata;
    logic [1:0]  irq_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] d;

    int prio_m [NSRC];
    bit pend_m [NSRC];

    always #2.5 clk = ~clk;

    plic_top dut_i (
        .clk(clk), .rst(rst), .src_req(src_req), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
        .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    function automatic logic [23:0] a_prio(input int s); return 24'(4 * s); endfunction
    function automatic logic [23:0] a_pend(input int w); return 24'(32'h1000 + 4 * w); endfunction
    function automatic logic [23:0] a_en(input int c, input int w); return 24'(32'h2000 + 32'h80 * c + 4 * w); endfunction
    function automatic logic [23:0] a_thr(input int c); return 24'(32'h20_0000 + 32'h1000 * c); endfunction
    function automatic logic [23:0] a_clm(input int c); return 24'(32'h20_0004 + 32'h1000 * c); endfunction
    function automatic bit is_level(input int s); return s >= 16; endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [23:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [23:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        v = reg_rdata;
    endtask

    task automatic pulse(input logic [31:0] mask);
        @(negedge clk);
        src_req = mask;
        @(negedge clk);
        src_req = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // model: best source for a context given enable mask and threshold
    function automatic int model_best(input logic [31:0] en, input int thr);
        int b = 0;
        for (int s = 1; s < NSRC; s++)
            if (pend_m[s] && en[s] && prio_m[s] > thr && (b == 0 || prio_m[s] > prio_m[b]))
                b = s;
        return b;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 irq", 32'(irq_o), 0);
        rd(a_prio(5), d);  chk("R1 prio", d, 0);
        rd(a_en(1, 0), d); chk("R1 enable", d, 0);
        rd(a_thr(1), d);   chk("R1 thr", d, 0);
        rd(a_pend(0), d);  chk("R1 pend", d, 0);
        rd(a_clm(0), d);   chk("R1/R5 empty claim", d, 0);

        // R2 priority width and reserved source 0
        wr(a_prio(3), 32'hFF); rd(a_prio(3), d); chk("R2 prio mask", d, 7);
        wr(a_prio(3), 0);
        wr(a_prio(0), 5);      rd(a_prio(0), d); chk("R2 src0 prio", d, 0);
        wr(a_en(0, 0), 32'h1); rd(a_en(0, 0), d); chk("R2 src0 enable", d, 0);
        pulse(32'h1); idle(2);
        rd(a_pend(0), d); chk("R2 src0 pend", d, 0);
        chk("R2 src0 irq", 32'(irq_o), 0);

        // R9 read-only pending and unmapped offsets
        wr(a_pend(0), 32'hFFFF_FFFF); rd(a_pend(0), d); chk("R9 pend ro", d, 0);
        rd(24'h000F00, d); chk("R9 gap", d, 0);
        rd(a_en(0, 1), d); chk("R9 en word", d, 0);
        rd(24'h200008, d); chk("R9 ctx gap", d, 0);
        rd(24'h000006, d); chk("R9 unaligned", d, 0);

        // R4 R5 R6 R7 R8: per-source sweep
        for (int s = 1; s < NSRC; s++) begin
            wr(a_prio(s), 32'(s % 7 + 1));
            wr(a_en(0, 0), 32'(1) << s);
            pulse(32'(1) << s);
            idle(1);
            chk("R4 irq up", 32'(irq_o), 1);
            rd(a_pend(0), d); chk("R6 pend set", d, 32'(1) << s);
            rd(a_clm(0), d);  chk("R5 claim id", d, 32'(s));
            idle(1);
            chk("R4 irq down", 32'(irq_o), 0);
            pulse(32'(1) << s); idle(1);
            rd(a_pend(0), d); chk("R6 busy blocks", d, 0);
            if (is_level(s)) begin
                wr(a_clm(1), 32'(s)); idle(2);
                rd(a_pend(0), d); chk("R8 foreign complete", d, 0);
            end
            wr(a_clm(0), 32'(s));
            rd(a_pend(0), d);
            chk("R7 after complete", d, is_level(s) ? (32'(1) << s) : 32'd0);
            if (is_level(s)) begin
                rd(a_clm(0), d); chk("R7 relatched claim", d, 32'(s));
                wr(a_clm(0), 32'(s));
            end
            wr(a_prio(s), 0);
            wr(a_en(0, 0), 0);
        end

        // R3 threshold sweep with source 4 held pending
        wr(a_en(0, 0), 32'h10); wr(a_en(1, 0), 32'h10);
        pulse(32'h10);
        for (int p = 1; p < 8; p++) begin
            for (int t = 0; t < 8; t++) begin
                wr(a_prio(4), 32'(p));
                wr(a_thr(0), 32'(t));
                wr(a_thr(1), 32'((t + 3) % 8));
                idle(1);
                chk("R3 thr ctx0", 32'(irq_o[0]), 32'(p > t));
                chk("R3 thr ctx1", 32'(irq_o[1]), 32'(p > (t + 3) % 8));
            end
        end
        wr(a_thr(0), 0); wr(a_thr(1), 0);
        rd(a_clm(0), d); chk("R5 thr claim", d, 4);
        wr(a_clm(0), 4);
        wr(a_prio(4), 0); wr(a_en(0, 0), 0); wr(a_en(1, 0), 0);

        // R3 context separation
        wr(a_prio(9), 2); wr(a_en(1, 0), 32'h200); wr(a_thr(1), 1);
        pulse(32'h200); idle(1);
        chk("R3 ctx1 only", 32'(irq_o), 2);
        rd(a_clm(0), d); chk("R3 ctx0 claim", d, 0);
        rd(a_clm(1), d); chk("R3 ctx1 claim", d, 9);
        wr(a_clm(1), 9);
        wr(a_prio(9), 0); wr(a_en(1, 0), 0); wr(a_thr(1), 0);

        // R5 full drain with priority ordering and ties
        for (int s = 1; s < NSRC; s++) begin
            prio_m[s] = (s * 5) % 8;
            pend_m[s] = 1'b1;
            wr(a_prio(s), 32'(prio_m[s]));
        end
        prio_m[0] = 0; pend_m[0] = 1'b0;
        wr(a_en(0, 0), 32'hFFFF_FFFE);
        wr(a_en(1, 0), 32'h0000_FFFE);
        pulse(32'hFFFF_FFFE);
        begin
            int e;
            e = model_best(32'h0000_FFFE, 0);
            rd(a_clm(1), d); chk("R5 ctx1 order", d, 32'(e));
            pend_m[e] = 1'b0;
            for (int k = 0; k < 40; k++) begin
                e = model_best(32'hFFFF_FFFE, 0);
                rd(a_clm(0), d); chk("R5 order", d, 32'(e));
                if (e == 0) break;
                pend_m[e] = 1'b0;
            end
        end
        rd(a_pend(0), d); chk("R5 prio0 stay", d, 32'h0101_0100);
        for (int s = 1; s < NSRC; s++) wr(a_clm(0), 32'(s));
        wr(a_prio(8), 1); wr(a_prio(16), 1); wr(a_prio(24), 1);
        rd(a_clm(0), d); chk("R5 tie lowest", d, 8);
        rd(a_clm(0), d); chk("R5 tie next", d, 16);
        rd(a_clm(0), d); chk("R5 tie last", d, 24);
        wr(a_clm(0), 8); wr(a_clm(0), 16); wr(a_clm(0), 24);
        for (int s = 1; s < NSRC; s++) wr(a_prio(s), 0);
        wr(a_en(1, 0), 0);

        // R10 claim and new request in the same cycle
        wr(a_en(0, 0), 32'h60); wr(a_prio(5), 2); wr(a_prio(6), 1);
        pulse(32'h20); idle(1);
        @(negedge clk);
        reg_addr = a_clm(0); reg_rd = 1'b1; src_req = 32'h40;
        @(negedge clk);
        reg_rd = 1'b0; src_req = '0;
        chk("R10 claim", reg_rdata, 5);
        rd(a_pend(0), d); chk("R10 new pend", d, 32'h40);
        // R11 read data holds without a read strobe
        idle(3);
        chk("R11 hold", reg_rdata, 32'h40);
        rd(a_clm(0), d); chk("R10 second claim", d, 6);
        wr(a_clm(0), 5); wr(a_clm(0), 6);
        idle(2);
        chk("R4 final irq", 32'(irq_o), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule